// File: doc/BRIEF.md
# Energy Level Rebroadcast Frame Transmitter

This block turns a validated 16-bit beam energy reading into one of 32 coarse levels and sends that level downstream inside a fixed 32-bit serial frame. A threshold table, given as a parameter, sets the conversion. The level is stored when the upstream receiver strobes a valid reading. A toggle bit in the frame inverts each time a new level is stored, so downstream cards can tell that the value is fresh.

The frame also carries control information. A test controller can ask one chosen processing card to force a dump on either the unmaskable or the maskable permit path. Four flags come in from the interlock side. A flag reports that both upstream energy links are broken. While that flag is set, the most conservative level (31) is sent in place of the stored one. A 4-bit CRC closes the frame. The frame is Manchester coded and leaves on two identical lines at a fixed repetition period. Each line feeds up to 16 cards in parallel.

Top module: `energy_level_tx`

## Requirements
- R1: On a cycle with `energy_vld_i` high and `both_broken_i` low, the stored level becomes the number of threshold entries k (k = 1..31, entry k at `THRESH[(k-1)*16 +: 16]`, ascending) for which `energy_i` >= entry k. An energy equal to entry k gives level k, and one below entry 1 gives level 0. With `energy_vld_i` low, the stored level is kept.
- R2: Each frame is sent MSB first as bits [31:24] = 8'b10010000, [23:8] = composite word, [7] = toggle, [6:4] = 3'b000, [3:0] = CRC.
- R3: The composite word is laid out as [4:0] level, [5] both-broken flag, [6] path select (1 = unmaskable, 0 = maskable), [7] forced-dump enable, [11:8] target card number, [15:12] interlock flags.
- R4: While `both_broken_i` is high, the level field is 31 and bit 5 is 1. A valid strobe in that state changes neither the stored level nor the toggle, so the old level comes back once the flag clears.
- R5: The toggle bit resets to 0 and inverts on every cycle in which a level is stored per R1.
- R6: The CRC is x^4+x+1 with initial value 0 and no final inversion. It is computed MSB first over frame bits [31:4], so the remainder of {bits[31:4], 4'b0} divided by 5'b10011 is zero after the CRC is appended.
- R7: Each bit takes two halves of `HALF_BIT_CYC` cycles each. A 1 is sent high then low, and a 0 is sent low then high. The line is low whenever no frame is in progress.
- R8: `link_a_o` and `link_b_o` carry the same waveform at all times.
- R9: After reset both lines are low and held low. The first frame starts on the first clock after reset release and carries level 0 and toggle 0. Later frames start every `FRAME_CYC` cycles.
- R10: The composite fields and the toggle are sampled once, when a frame starts. Input changes during a frame do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| energy_i | input | 16 | Validated energy reading |
| energy_vld_i | input | 1 | Strobe: store a new level from `energy_i` |
| both_broken_i | input | 1 | Both upstream energy links are broken |
| dump_en_i | input | 1 | Request a forced dump on the target card |
| dump_unmask_i | input | 1 | Forced dump path: 1 unmaskable, 0 maskable |
| dump_card_i | input | 4 | Target card number 0..15 |
| ilk_flags_i | input | 4 | Flags from the interlock side |
| link_a_o | output | 1 | Serial line A, Manchester coded |
| link_b_o | output | 1 | Serial line B, same waveform as A |

## Verification
The conversion is driven with energies at a threshold and one count below it, zero, the top of the range, and a value between entries. These values separate an off-by-one compare or table index from a correct one. Control fields are set to all-ones and to alternating patterns, which exposes any swap or shift in the composite layout and gives the CRC varied input. Strobe-less updates and strobes during the broken state show whether the level and toggle are held correctly, while the substitute level is on the line. A change of input in the middle of a frame shows whether the fields are sampled at the frame boundary. Every bit half of both lines is compared, which checks the Manchester polarity and that the two links stay identical.

// File: rtl/energy_level_tx.sv
module energy_level_tx #(
  parameter int HALF_BIT_CYC = 50,
  parameter int FRAME_CYC    = 100000,
  parameter logic [31*16-1:0] THRESH = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] energy_i,
  input  logic        energy_vld_i,
  input  logic        both_broken_i,
  input  logic        dump_en_i,
  input  logic        dump_unmask_i,
  input  logic [3:0]  dump_card_i,
  input  logic [3:0]  ilk_flags_i,
  output logic        link_a_o,
  output logic        link_b_o
);
  localparam int NLVL  = 32;
  localparam int LVL_W = $clog2(NLVL);
  localparam int NTH   = NLVL - 1;
  localparam int EW    = 16;
  localparam int FR_W  = 32;
  localparam int BIT_W = $clog2(FR_W);
  localparam int HC_W  = $clog2(HALF_BIT_CYC + 1);
  localparam int PC_W  = $clog2(FRAME_CYC + 1);
  localparam logic [7:0] HDR  = 8'b1001_0000;
  localparam logic [3:0] POLY = 4'b0011;

  function automatic logic [NTH*EW-1:0] uniform_tbl();
    logic [NTH*EW-1:0] t;
    for (int k = 1; k <= NTH; k++) t[(k-1)*EW +: EW] = EW'(k * ((2**EW) / NLVL));
    return t;
  endfunction

  localparam logic [NTH*EW-1:0] TBL = (THRESH == '0) ? uniform_tbl() : THRESH;

  function automatic logic [3:0] crc4(input logic [FR_W-5:0] d);
    logic [3:0] c;
    logic fb;
    c = '0;
    for (int i = FR_W - 5; i >= 0; i--) begin
      fb = c[3] ^ d[i];
      c = {c[2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  logic [LVL_W-1:0] lvl_conv, lvl_q, lvl_tx;
  logic             tog_q;
  logic [15:0]      comp;
  logic [FR_W-5:0]  body;
  logic [FR_W-1:0]  frame_w, sh_q;
  logic [PC_W-1:0]  per_q;
  logic [HC_W-1:0]  hc_q;
  logic [BIT_W-1:0] bit_q;
  logic             busy_q, half_q, start;

  always_comb begin
    lvl_conv = '0;
    for (int k = 0; k < NTH; k++)
      if (energy_i >= TBL[k*EW +: EW]) lvl_conv = LVL_W'(k + 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      tog_q <= 1'b0;
    end else if (energy_vld_i && !both_broken_i) begin
      lvl_q <= lvl_conv;
      tog_q <= ~tog_q;
    end
  end

  assign lvl_tx  = both_broken_i ? '1 : lvl_q;
  assign comp    = {ilk_flags_i, dump_card_i, dump_en_i, dump_unmask_i, both_broken_i, lvl_tx};
  assign body    = {HDR, comp, tog_q, 3'b000};
  assign frame_w = {body, crc4(body)};
  assign start   = (per_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) per_q <= '0;
    else        per_q <= (per_q == PC_W'(FRAME_CYC - 1)) ? '0 : per_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      busy_q <= 1'b0;
      half_q <= 1'b0;
      hc_q   <= '0;
      bit_q  <= '0;
    end else if (start) begin
      sh_q   <= frame_w;
      busy_q <= 1'b1;
      half_q <= 1'b0;
      hc_q   <= '0;
      bit_q  <= '0;
    end else if (busy_q) begin
      if (hc_q == HC_W'(HALF_BIT_CYC - 1)) begin
        hc_q   <= '0;
        half_q <= ~half_q;
        if (half_q) begin
          sh_q  <= {sh_q[FR_W-2:0], 1'b0};
          bit_q <= bit_q + 1'b1;
          if (bit_q == BIT_W'(FR_W - 1)) busy_q <= 1'b0;
        end
      end else begin
        hc_q <= hc_q + 1'b1;
      end
    end
  end

  assign link_a_o = busy_q & (sh_q[FR_W-1] ^ half_q);
  assign link_b_o = busy_q & (sh_q[FR_W-1] ^ half_q);
endmodule

module energy_level_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vld,
  input logic       brk,
  input logic       link_a,
  input logic       link_b,
  input logic       busy,
  input logic       half,
  input logic [4:0] lvl,
  input logic       tog
);
  // R8
  links_match_chk: assert property (@(posedge clk) disable iff (!rst_n) link_a == link_b);
  // R7
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !link_a);
  // R7
  mid_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $rose(half) |-> link_a != $past(link_a));
  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld && !brk |=> tog != $past(tog));
  // R4
  broken_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> $stable(lvl) && $stable(tog));
endmodule

bind energy_level_tx energy_level_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .vld(energy_vld_i), .brk(both_broken_i),
  .link_a(link_a_o), .link_b(link_b_o), .busy(busy_q), .half(half_q),
  .lvl(lvl_q), .tog(tog_q)
);

// File: tb/energy_level_tx_tb.sv
module energy_level_tx_tb_top;
  localparam int H = 2;
  localparam int P = 200;
  localparam int NV = 12;

  function automatic logic [31*16-1:0] sq_tbl();
    logic [31*16-1:0] t;
    for (int k = 1; k <= 31; k++) t[(k-1)*16 +: 16] = 16'(k * k * 64);
    return t;
  endfunction

  // {energy[15:0], vld, brk, dump_en, unmask, card[3:0], flags[3:0]}
  localparam logic [27:0] VEC [NV] = '{
    {16'd0,     1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  4'h0},
    {16'd64,    1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  4'h0},
    {16'd63,    1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  4'h0},
    {16'd61504, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  4'h0},
    {16'd65535, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0,  4'h0},
    {16'd2500,  1'b1, 1'b0, 1'b0, 1'b0, 4'd9,  4'h0},
    {16'd3136,  1'b1, 1'b0, 1'b1, 1'b1, 4'd15, 4'hA},
    {16'd1000,  1'b1, 1'b0, 1'b1, 1'b0, 4'd0,  4'h5},
    {16'd50000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6,  4'hF},
    {16'd100,   1'b1, 1'b1, 1'b0, 1'b0, 4'd3,  4'h0},
    {16'd200,   1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  4'h0},
    {16'd40000, 1'b1, 1'b0, 1'b1, 1'b0, 4'd12, 4'h3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] energy = '0;
  logic vld = 1'b0, brk = 1'b0, den = 1'b0, unm = 1'b0;
  logic [3:0] card = '0, flags = '0;
  logic link_a, link_b;

  int nchk = 0, nfail = 0;
  logic [4:0] m_lvl = '0;
  logic m_tog = 1'b0;
  logic [31:0] fr;
  bit man_ok, ab_ok;
  realtime t0, t1;

  always #5 clk = ~clk;

  energy_level_tx #(.HALF_BIT_CYC(H), .FRAME_CYC(P), .THRESH(sq_tbl())) dut_i (
    .clk(clk), .rst_n(rst_n), .energy_i(energy), .energy_vld_i(vld),
    .both_broken_i(brk), .dump_en_i(den), .dump_unmask_i(unm),
    .dump_card_i(card), .ilk_flags_i(flags), .link_a_o(link_a), .link_b_o(link_b));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [4:0] ref_level(input logic [15:0] e);
    int l = 0;
    while (l < 31 && int'(e) >= (l + 1) * (l + 1) * 64) l++;
    return 5'(l);
  endfunction

  function automatic logic [3:0] ref_crc(input logic [27:0] d);
    logic [31:0] v = {d, 4'b0};
    for (int i = 31; i >= 4; i--) if (v[i]) v = v ^ (32'b10011 << (i - 4));
    return v[3:0];
  endfunction

  function automatic logic [31:0] ref_frame(input logic [4:0] l, input logic b, input logic de,
      input logic um, input logic [3:0] c, input logic [3:0] f, input logic t);
    logic [27:0] d = {8'h90, f, c, de, um, b, (b ? 5'd31 : l), t, 3'b000};
    return {d, ref_crc(d)};
  endfunction

  task automatic capture(output logic [31:0] f, output bit mok, output bit abok, output realtime ts);
    logic a1, a2;
    mok = 1; abok = 1;
    @(posedge link_a);
    ts = $realtime;
    #5;
    for (int b = 31; b >= 0; b--) begin
      a1 = link_a;
      if (link_b !== link_a) abok = 0;
      #(H * 10);
      a2 = link_a;
      if (link_b !== link_a) abok = 0;
      if (a2 !== ~a1) mok = 0;
      f[b] = a1;
      #(H * 10);
    end
  endtask

  task automatic apply(input logic [27:0] v);
    repeat (10) @(negedge clk);
    {energy, vld, brk, den, unm, card, flags} = v;
    if (vld && !brk) begin
      m_lvl = ref_level(energy);
      m_tog = ~m_tog;
    end
    @(negedge clk);
    vld = 1'b0;
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 lines held low in reset
    check("R9 reset lines", {link_a, link_b}, 2'b00);
    rst_n = 1'b1;
    capture(fr, man_ok, ab_ok, t0);
    // R9 first frame: level 0, toggle 0
    check("R9 first frame", fr, ref_frame(5'd0, 0, 0, 0, 4'd0, 4'd0, 0));
    capture(fr, man_ok, ab_ok, t1);
    check("R9 frame period", 32'(int'((t1 - t0) / 10.0)), 32'(P));
    // R7 idle gap low
    repeat (20) @(negedge clk);
    check("R7 idle low", {link_a, link_b}, 2'b00);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      capture(fr, man_ok, ab_ok, t0);
      check($sformatf("R1 R2 R3 R4 frame vec %0d", i), fr,
            ref_frame(m_lvl, brk, den, unm, card, flags, m_tog));
      check($sformatf("R5 toggle vec %0d", i), 32'(fr[7]), 32'(m_tog));
      check($sformatf("R6 crc vec %0d", i), 32'(fr[3:0]), 32'(ref_crc(fr[31:4])));
      check($sformatf("R7 manchester vec %0d", i), 32'(man_ok), 32'd1);
      check($sformatf("R8 links equal vec %0d", i), 32'(ab_ok), 32'd1);
    end

    // R10 inputs changed mid-frame do not reach the current frame
    apply({16'd5000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 4'h1});
    fork
      capture(fr, man_ok, ab_ok, t0);
      begin
        @(posedge link_a);
        repeat (30) @(negedge clk);
        flags = 4'hE;
        card = 4'd7;
        brk = 1'b1;
      end
    join
    check("R10 mid-frame sample", fr, ref_frame(m_lvl, 0, 0, 0, 4'd2, 4'h1, m_tog));
    capture(fr, man_ok, ab_ok, t0);
    check("R10 R4 next frame", fr, ref_frame(m_lvl, 1, 0, 0, 4'd7, 4'hE, m_tog));

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule